// File: doc/BRIEF.md
# Quad-Wiper Register Command Slave

This block is the serial command front end of a four-channel digital potentiometer register bank. It oversamples a two-wire bus (SCL and SDA) on the system clock, detects START and STOP conditions, and decodes a three-part command. The first part is an address byte carrying a fixed device-type nibble and a pin-strapped sub-address. The second is an instruction byte that packs an opcode, a data-register index and a wiper index into one byte. Write commands add a third part, a data byte.

The register bank holds four wiper control registers, whose contents drive the wiper outputs, and sixteen data registers, four for each wiper. Commands can write either kind of register, read either kind back over the bus, or copy between a wiper register and one of its data registers. SDA is never driven high. The block only asks for a low level through `sda_oe_o`, and the board provides the pull-up.

Top module: `quad_wiper_i2c_slave`

## Requirements
- R1: After reset every wiper and data register is zero, `busy_o` is low, `sda_oe_o` is low, and the block waits for a START.
- R2: The address byte is received MSB first. It is acknowledged (SDA pulled low during the ninth clock) only if bits 7..4 equal 0101 and bits 3..0 equal `dev_addr_i`.
- R3: After an address byte that does not match, the block drives no acknowledge or data and changes no register until the next START.
- R4: In the instruction byte, bits 7..4 are the opcode, bits 3..2 select the data register (00 to 11 give index 0 to 3), and bits 1..0 select the wiper (0 to 3).
- R5: An opcode outside {1010, 1100, 1001, 1011, 1101, 1110} is not acknowledged, and the command changes no register.
- R6: Opcode 1010 writes the data byte into the selected wiper register. Opcode 1100 writes it into the selected data register. The data byte is acknowledged, and the register changes only after that acknowledge clock ends.
- R7: Opcode 1001 returns the selected wiper register and opcode 1011 returns the selected data register. The value is sent MSB first on the eight clocks that follow the instruction acknowledge.
- R8: Opcode 1101 copies the selected data register into its wiper register. Opcode 1110 copies the wiper register into the selected data register. Either copy happens only at the STOP that follows the instruction byte.
- R9: A STOP or a repeated START before a command completes leaves every register unchanged.
- R10: `busy_o` is high from a START until a STOP returns the block to idle.
- R11: `wiper_o[8p+7:8p]` always shows wiper register p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| dev_addr_i | input | 4 | Strapped sub-address |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | A bus frame is in progress |
| wiper_o | output | 32 | Four 8-bit wiper register values |

## Verification
Both bus lines pass through two synchronizer flops and one edge-detect flop, so the block reacts to an SCL edge three clocks after it occurs. The bench holds every bus phase for four clocks, which means acknowledge and read bits are sampled while SCL is high, after the slave has settled. A register written by a command is updated one clock after the acknowledge-ending SCL fall is detected, and a copy is updated one clock after the STOP is detected. The bench therefore waits eight idle clocks after each STOP before it re-enables its every-clock comparison of `wiper_o` against the behavioural register model.

// File: rtl/qw_pkg.sv
package qw_pkg;
  localparam int BYTE_W        = 8;
  localparam int NUM_WIPERS    = 4;
  localparam int DRS_PER_WIPER = 4;
  localparam int WIDX_W        = $clog2(NUM_WIPERS);
  localparam int DIDX_W        = $clog2(DRS_PER_WIPER);
  localparam int OP_W          = BYTE_W - WIDX_W - DIDX_W;

  typedef enum logic [3:0] {
    OP_WR_WCR = 4'b1010,
    OP_WR_DR  = 4'b1100,
    OP_RD_WCR = 4'b1001,
    OP_RD_DR  = 4'b1011,
    OP_DR2WCR = 4'b1101,
    OP_WCR2DR = 4'b1110
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_RX, ST_TX, ST_WAIT_STOP, ST_IGNORE
  } st_e;

  function automatic logic op_known(input logic [3:0] op);
    return op inside {OP_WR_WCR, OP_WR_DR, OP_RD_WCR, OP_RD_DR, OP_DR2WCR, OP_WCR2DR};
  endfunction

  function automatic logic op_is_write(input logic [3:0] op);
    return op inside {OP_WR_WCR, OP_WR_DR};
  endfunction

  function automatic logic op_is_read(input logic [3:0] op);
    return op inside {OP_RD_WCR, OP_RD_DR};
  endfunction

  function automatic logic op_is_xfer(input logic [3:0] op);
    return op inside {OP_DR2WCR, OP_WCR2DR};
  endfunction
endpackage

// File: rtl/qw_bus_sampler.sv
module qw_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_q[SYNC_STAGES-1];
      sda_d <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_q[SYNC_STAGES-1];
  assign sda_o      = sda_q[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges while SCL stays high mark frame boundaries
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/qw_frame_ctrl.sv
module qw_frame_ctrl
  import qw_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [3:0]        dev_addr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              busy_o,
  output st_e               state_o,
  output logic              cmd_valid_o,
  output logic [OP_W-1:0]   cmd_op_o,
  output logic [DIDX_W-1:0] cmd_dr_o,
  output logic [WIDX_W-1:0] cmd_wiper_o,
  output logic [BYTE_W-1:0] cmd_data_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  st_e               state_q, nxt_q;
  logic [BYTE_W-1:0] sr_q, instr_q, data_q, tx_sr_q;
  logic [CNT_W-1:0]  cnt_q, tx_cnt_q;
  logic              ack_ph_q, oe_q, xfer_pend_q, cmd_valid_q;
  logic              addr_hit;
  logic [3:0]        sr_op;

  assign addr_hit = (sr_q[7:4] == DEV_TYPE) && (sr_q[3:0] == dev_addr_i);
  assign sr_op    = sr_q[7:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      nxt_q       <= ST_IDLE;
      sr_q        <= '0;
      instr_q     <= '0;
      data_q      <= '0;
      tx_sr_q     <= '0;
      cnt_q       <= '0;
      tx_cnt_q    <= '0;
      ack_ph_q    <= 1'b0;
      oe_q        <= 1'b0;
      xfer_pend_q <= 1'b0;
      cmd_valid_q <= 1'b0;
    end else begin
      cmd_valid_q <= 1'b0;
      if (start_i) begin
        state_q     <= ST_ADDR;
        cnt_q       <= '0;
        ack_ph_q    <= 1'b0;
        oe_q        <= 1'b0;
        xfer_pend_q <= 1'b0;
      end else if (stop_i) begin
        if (state_q == ST_WAIT_STOP && xfer_pend_q) cmd_valid_q <= 1'b1;
        state_q     <= ST_IDLE;
        ack_ph_q    <= 1'b0;
        oe_q        <= 1'b0;
        xfer_pend_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_INSTR, ST_RX: begin
            if (scl_rise_i && !ack_ph_q && cnt_q != FULL) begin
              sr_q  <= {sr_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end
            if (scl_fall_i) begin
              if (ack_ph_q) begin
                // acknowledge clock over: release and move on
                ack_ph_q <= 1'b0;
                oe_q     <= 1'b0;
                cnt_q    <= '0;
                state_q  <= nxt_q;
                if (state_q == ST_RX) cmd_valid_q <= 1'b1;
                if (nxt_q == ST_TX) begin
                  tx_sr_q  <= rd_data_i;
                  tx_cnt_q <= '0;
                  oe_q     <= ~rd_data_i[BYTE_W-1];
                end
              end else if (cnt_q == FULL) begin
                unique case (state_q)
                  ST_ADDR: begin
                    if (addr_hit) begin
                      oe_q     <= 1'b1;
                      ack_ph_q <= 1'b1;
                      nxt_q    <= ST_INSTR;
                    end else begin
                      state_q <= ST_IGNORE;
                    end
                  end
                  ST_INSTR: begin
                    instr_q <= sr_q;
                    if (op_known(sr_op)) begin
                      oe_q        <= 1'b1;
                      ack_ph_q    <= 1'b1;
                      xfer_pend_q <= op_is_xfer(sr_op);
                      nxt_q       <= op_is_write(sr_op) ? ST_RX :
                                     op_is_read(sr_op)  ? ST_TX : ST_WAIT_STOP;
                    end else begin
                      state_q <= ST_WAIT_STOP;
                    end
                  end
                  default: begin
                    data_q   <= sr_q;
                    oe_q     <= 1'b1;
                    ack_ph_q <= 1'b1;
                    nxt_q    <= ST_WAIT_STOP;
                  end
                endcase
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (tx_cnt_q == LAST) begin
                oe_q    <= 1'b0;
                state_q <= ST_WAIT_STOP;
              end else begin
                oe_q     <= ~tx_sr_q[BYTE_W-2];
                tx_sr_q  <= tx_sr_q << 1;
                tx_cnt_q <= tx_cnt_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign state_o     = state_q;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_op_o    = instr_q[BYTE_W-1 -: OP_W];
  assign cmd_dr_o    = instr_q[WIDX_W +: DIDX_W];
  assign cmd_wiper_o = instr_q[WIDX_W-1:0];
  assign cmd_data_o  = data_q;
endmodule

// File: rtl/qw_reg_bank.sv
module qw_reg_bank
  import qw_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cmd_valid_i,
  input  logic [OP_W-1:0]              cmd_op_i,
  input  logic [DIDX_W-1:0]            cmd_dr_i,
  input  logic [WIDX_W-1:0]            cmd_wiper_i,
  input  logic [BYTE_W-1:0]            cmd_data_i,
  output logic [BYTE_W-1:0]            rd_data_o,
  output logic [NUM_WIPERS*BYTE_W-1:0] wiper_o
);
  logic [BYTE_W-1:0] wcr_a [NUM_WIPERS];
  logic [BYTE_W-1:0] dr_a  [NUM_WIPERS][DRS_PER_WIPER];

  for (genvar p = 0; p < NUM_WIPERS; p++) begin : g_wiper
    logic [BYTE_W-1:0] wcr_r;
    logic              sel_w;
    assign sel_w = cmd_valid_i && (cmd_wiper_i == WIDX_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wcr_r <= '0;
      else if (sel_w) begin
        case (op_e'(cmd_op_i))
          OP_WR_WCR: wcr_r <= cmd_data_i;
          OP_DR2WCR: wcr_r <= dr_a[p][cmd_dr_i];
          default: ;
        endcase
      end
    end

    assign wcr_a[p] = wcr_r;
    assign wiper_o[p*BYTE_W +: BYTE_W] = wcr_r;

    for (genvar r = 0; r < DRS_PER_WIPER; r++) begin : g_dr
      logic [BYTE_W-1:0] dr_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dr_r <= '0;
        else if (sel_w && cmd_dr_i == DIDX_W'(r)) begin
          case (op_e'(cmd_op_i))
            OP_WR_DR:  dr_r <= cmd_data_i;
            OP_WCR2DR: dr_r <= wcr_r;
            default: ;
          endcase
        end
      end
      assign dr_a[p][r] = dr_r;
    end
  end

  always_comb begin
    if (cmd_op_i == OP_RD_WCR) rd_data_o = wcr_a[cmd_wiper_i];
    else                       rd_data_o = dr_a[cmd_wiper_i][cmd_dr_i];
  end
endmodule

// File: rtl/quad_wiper_i2c_slave.sv
module quad_wiper_i2c_slave
  import qw_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE    = 4'b0101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [3:0]  dev_addr_i,
  output logic        sda_oe_o,
  output logic        busy_o,
  output logic [31:0] wiper_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_e               state_q;
  logic              cmd_valid;
  logic [OP_W-1:0]   cmd_op;
  logic [DIDX_W-1:0] cmd_dr;
  logic [WIDX_W-1:0] cmd_wiper;
  logic [BYTE_W-1:0] cmd_data, rd_data;

  qw_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  qw_frame_ctrl #(.DEV_TYPE(DEV_TYPE)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_s_i     (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .dev_addr_i  (dev_addr_i),
    .rd_data_i   (rd_data),
    .sda_oe_o    (sda_oe_o),
    .busy_o      (busy_o),
    .state_o     (state_q),
    .cmd_valid_o (cmd_valid),
    .cmd_op_o    (cmd_op),
    .cmd_dr_o    (cmd_dr),
    .cmd_wiper_o (cmd_wiper),
    .cmd_data_o  (cmd_data)
  );

  qw_reg_bank u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid),
    .cmd_op_i    (cmd_op),
    .cmd_dr_i    (cmd_dr),
    .cmd_wiper_i (cmd_wiper),
    .cmd_data_i  (cmd_data),
    .rd_data_o   (rd_data),
    .wiper_o     (wiper_o)
  );
endmodule

// File: rtl/qw_checker.sv
module qw_checker
  import qw_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            scl_s,
  input logic            stop_det,
  input logic            busy_o,
  input logic            sda_oe_o,
  input st_e             state_q,
  input logic            cmd_valid,
  input logic [OP_W-1:0] cmd_op,
  input logic [31:0]     wiper_o
);
  a_r1_idle_never_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !sda_oe_o);

  a_r2_drive_changes_with_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  a_r3_ignored_frame_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IGNORE |-> !sda_oe_o);

  a_r8_copy_only_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid && (cmd_op == OP_DR2WCR || cmd_op == OP_WCR2DR) |-> $past(stop_det));

  a_r9_wipers_hold_without_command: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid |=> $stable(wiper_o));

  a_r10_stop_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !busy_o);
endmodule

bind quad_wiper_i2c_slave qw_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .stop_det  (stop_det),
  .busy_o    (busy_o),
  .sda_oe_o  (sda_oe_o),
  .state_q   (state_q),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .wiper_o   (wiper_o)
);

// File: tb/tb_quad_wiper_i2c_slave.sv
`timescale 1ns/1ps
module tb_quad_wiper_i2c_slave;
  localparam logic [3:0] DEV  = 4'b0101;
  localparam logic [3:0] ADDR = 4'b1011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy;
  logic [31:0] wiper;
  wire sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  quad_wiper_i2c_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_addr_i(ADDR), .sda_oe_o(sda_oe), .busy_o(busy), .wiper_o(wiper)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0, done = 0;
  logic [7:0] m_wcr [4];
  logic [7:0] m_dr  [16];

  function automatic logic [31:0] model_pack();
    return {m_wcr[3], m_wcr[2], m_wcr[1], m_wcr[0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-clock comparison of wiper outputs against the model while idle (R11)
  always @(negedge clk) if (cmp_en) check("R11", wiper, model_pack());

  task automatic hold(); repeat (4) @(negedge clk); endtask
  task automatic settle(); repeat (8) @(negedge clk); cmp_en = 1; endtask

  task automatic start_c();
    cmp_en = 0;
    sda_m = 1; hold(); scl_m = 1; hold(); sda_m = 0; hold(); scl_m = 0; hold();
  endtask

  task automatic stop_c();
    sda_m = 0; hold(); scl_m = 1; hold(); sda_m = 1; hold();
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hold(); scl_m = 1; hold(); scl_m = 0; hold();
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    put_bits(b, 8);
    sda_m = 1; hold(); scl_m = 1; hold(); ack = (sda_line == 1'b0); scl_m = 0; hold();
  endtask

  task automatic get_byte(output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hold(); scl_m = 1; hold(); b[i] = sda_line; scl_m = 0;
    end
    hold(); scl_m = 1; hold(); scl_m = 0; hold();
  endtask

  task automatic do_write(input logic [3:0] op, input logic [1:0] p, input logic [1:0] r,
                          input logic [7:0] d);
    logic a;
    start_c();
    put_byte({DEV, ADDR}, a); check("R2 addr ack", a, 1);
    put_byte({op, r, p}, a);  check("R4 instr ack", a, 1);
    put_byte(d, a);           check("R6 data ack", a, 1);
    stop_c();
    if (op == 4'b1010) m_wcr[p] = d; else m_dr[p*4 + r] = d;
    settle();
  endtask

  task automatic do_read(input logic [3:0] op, input logic [1:0] p, input logic [1:0] r,
                         output logic [7:0] d);
    logic a;
    start_c();
    put_byte({DEV, ADDR}, a); check("R2 addr ack", a, 1);
    put_byte({op, r, p}, a);  check("R7 instr ack", a, 1);
    get_byte(d);
    stop_c();
    settle();
  endtask

  task automatic do_xfer(input logic [3:0] op, input logic [1:0] p, input logic [1:0] r);
    logic a;
    start_c();
    put_byte({DEV, ADDR}, a); check("R2 addr ack", a, 1);
    put_byte({op, r, p}, a);  check("R8 instr ack", a, 1);
    check("R8 no copy before STOP", wiper, model_pack());
    stop_c();
    if (op == 4'b1101) m_wcr[p] = m_dr[p*4 + r]; else m_dr[p*4 + r] = m_wcr[p];
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < 4; i++) m_wcr[i] = '0;
    for (int i = 0; i < 16; i++) m_dr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 wipers zero", wiper, 32'h0);
    check("R1 busy low", busy, 0);
    check("R1 sda released", sda_oe, 0);
    do_read(4'b1011, 2'd3, 2'd3, d); check("R1 data register zero", d, 8'h00);
    cmp_en = 1;

    // R6 wiper write and packing
    do_write(4'b1010, 2'd2, 2'd0, 8'h5A);
    check("R11 wiper2 field", wiper[23:16], 8'h5A);

    // R6 / R7 data register write and read back
    do_write(4'b1100, 2'd1, 2'd3, 8'hC3);
    do_read(4'b1011, 2'd1, 2'd3, d); check("R7 read DR", d, 8'hC3);
    do_read(4'b1001, 2'd2, 2'd0, d); check("R7 read WCR", d, 8'h5A);

    // R8 copies
    do_xfer(4'b1101, 2'd1, 2'd3);
    check("R8 DR to WCR", wiper[15:8], 8'hC3);
    do_xfer(4'b1110, 2'd2, 2'd0);
    do_read(4'b1011, 2'd2, 2'd0, d); check("R8 WCR to DR", d, 8'h5A);

    // R4 field positions
    do_write(4'b1100, 2'd0, 2'd1, 8'h11);
    do_write(4'b1100, 2'd3, 2'd2, 8'h77);
    do_read(4'b1011, 2'd0, 2'd1, d); check("R4 p0 r1", d, 8'h11);
    do_read(4'b1011, 2'd3, 2'd2, d); check("R4 p3 r2", d, 8'h77);
    do_read(4'b1011, 2'd0, 2'd2, d); check("R4 p0 r2 untouched", d, 8'h00);

    // R3 wrong sub-address
    start_c();
    check("R10 busy after START", busy, 1);
    put_byte({DEV, ADDR ^ 4'b0001}, a); check("R3 no addr ack", a, 0);
    put_byte({4'b1010, 2'd0, 2'd0}, a);  check("R3 no instr ack", a, 0);
    put_byte(8'hEE, a);                  check("R3 no data ack", a, 0);
    stop_c(); settle();
    check("R10 busy cleared", busy, 0);

    // R2 wrong device type
    start_c();
    put_byte({4'b0110, ADDR}, a); check("R2 wrong type nack", a, 0);
    put_byte({4'b1010, 2'd0, 2'd0}, a); check("R3 silent after type miss", a, 0);
    stop_c(); settle();

    // R5 undefined opcode
    start_c();
    put_byte({DEV, ADDR}, a);           check("R2 addr ack", a, 1);
    put_byte({4'b0111, 2'd0, 2'd0}, a); check("R5 bad op nack", a, 0);
    put_byte(8'h99, a);                 check("R5 data ignored", a, 0);
    stop_c(); settle();

    // R9 STOP before data byte
    start_c();
    put_byte({DEV, ADDR}, a); put_byte({4'b1010, 2'd0, 2'd3}, a);
    stop_c(); settle();
    check("R9 stop abort", wiper, model_pack());

    // R9 repeated START inside data byte
    start_c();
    put_byte({DEV, ADDR}, a); put_byte({4'b1010, 2'd0, 2'd0}, a);
    put_bits(8'hFF, 3);
    start_c();
    stop_c(); settle();
    check("R9 restart abort", wiper[7:0], 8'h00);

    // R9 copy cancelled by repeated START
    start_c();
    put_byte({DEV, ADDR}, a); put_byte({4'b1101, 2'd1, 2'd0}, a);
    start_c();
    stop_c(); settle();
    check("R9 copy cancelled", wiper[7:0], 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule